// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block turns one source clock into three banks of divided clocks and one feedback clock. The source is the oscillator clock in normal operation. In bypass it is one of two reference clocks, picked by a select input. A shared doubling stage and a per-bank select pick each bank's ratio from a small table. A separate two-bit select indexes the feedback ratio. Every ratio is even, and every output has a 50% duty cycle.

All select inputs are captured while the active-low master reset / output enable is held low. They are frozen once it is released. Releasing it starts every divider from a common zero count, so all outputs rise together on the first source edge. Rising edges stay aligned wherever one ratio divides another.

An active-low clock-stop parks the bank outputs low without shortening a high pulse. The feedback output keeps running. While the master reset / output enable is low, all outputs are left undriven.

Top module: `clkdiv_bank_top`

## Requirements
- R1: In bypass, `ref_sel_i` = 0 makes reference clock 0 the source and `ref_sel_i` = 1 makes reference clock 1 the source.
- R2: `pll_en_i` = 1 clocks the dividers from `osc_clk_i`. `pll_en_i` = 0 clocks them directly from the selected reference clock, and a static reference holds every output at a fixed level.
- R3: Banks A and B divide the source by 4 (select 0) or 8 (select 1) when `vco_sel_i` = 0, and by 8 or 16 when `vco_sel_i` = 1.
- R4: Bank C divides by 8 (select 0) or 12 (select 1) when `vco_sel_i` = 0, and by 16 or 24 when `vco_sel_i` = 1.
- R5: The feedback ratio is indexed by {`vco_sel_i`, `fb_sel_i[1]`, `fb_sel_i[0]`}: 000→8, 001→16, 010→12, 011→24, 100→16, 101→32, 110→24, 111→48.
- R6: Bank A has 5 pins, bank B has 5 pins and bank C has 4 pins. Every pin of a bank carries the same value.
- R7: After release of reset, a divider of ratio N is high for the first N/2 source edges, starting at the first edge, and low for the next N/2 edges. This repeats, giving a 50% duty cycle with rising edges aligned across all outputs.
- R8: While `clk_stop_n_i` = 0, every bank output is held low and the feedback output keeps following its R7 waveform.
- R9: Clock-stop is applied to a bank only while that bank's divider phase is low. Every high pulse of a bank output therefore lasts exactly N/2 source edges, and after restart the output is back in phase with its R7 waveform.
- R10: While `mr_oe_n_i` = 0, no output drives high (outputs are released to high impedance), and every divider is cleared on each source edge.
- R11: Select inputs are registered only while `mr_oe_n_i` = 0. Changes after release have no effect on any ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock, the source when `pll_en_i` = 1 |
| ref0_clk_i | input | 1 | Reference clock 0 |
| ref1_clk_i | input | 1 | Reference clock 1 |
| ref_sel_i | input | 1 | Reference choice: 0 = reference 0, 1 = reference 1 |
| pll_en_i | input | 1 | 1 = oscillator source, 0 = bypass to selected reference |
| vco_sel_i | input | 1 | Shared doubling of all ratios |
| sel_a_i | input | 1 | Bank A ratio select |
| sel_b_i | input | 1 | Bank B ratio select |
| sel_c_i | input | 1 | Bank C ratio select |
| fb_sel_i | input | 2 | Feedback ratio select |
| clk_stop_n_i | input | 1 | Active-low stop for bank outputs |
| mr_oe_n_i | input | 1 | Active-low master reset and output disable |
| bank_a_o | output | NUM_A | Bank A clocks |
| bank_b_o | output | NUM_B | Bank B clocks |
| bank_c_o | output | NUM_C | Bank C clocks |
| fb_o | output | 1 | Feedback clock |

## Verification
Every output is a register on the source clock, so the divided value for source edge k appears right after edge k. The bench counts edge 1 as the first edge with reset released and samples on each following falling edge, so sample k is compared against the R7 waveform for edge k.

A clock-stop change waits for the bank's next low phase, which can take up to N/2 + 1 edges. The bench therefore checks parked-low outputs only from 20 edges after the stop. It checks the restarted phase only 30 edges after the release.

Bypass periods are measured in time, between two rising edges of an output. The measurement starts only after enough edges have passed to flush any switch of the source mux.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // half-period counter width; holds up to 2*24-1
  localparam int CNT_W = 6;
  typedef logic [CNT_W-1:0] half_t;

  typedef struct packed {
    logic       vco;
    logic       a;
    logic       b;
    logic       c;
    logic [1:0] fb;
  } sel_t;

  function automatic half_t scale_half(half_t base, logic dbl);
    return dbl ? half_t'(base << 1) : base;
  endfunction
endpackage

// File: rtl/clkdiv_src_mux.sv
`timescale 1ns/1ps
module clkdiv_src_mux (
  input  logic osc_clk_i,
  input  logic ref0_clk_i,
  input  logic ref1_clk_i,
  input  logic ref_sel_i,
  input  logic pll_en_i,
  output logic src_clk_o
);
  logic ref_clk;
  assign ref_clk   = ref_sel_i ? ref1_clk_i : ref0_clk_i;
  assign src_clk_o = pll_en_i ? osc_clk_i : ref_clk;
endmodule

// File: rtl/clkdiv_ratio_dec.sv
`timescale 1ns/1ps
module clkdiv_ratio_dec
  import clkdiv_pkg::*;
(
  input  sel_t  sel_i,
  output half_t half_a_o,
  output half_t half_b_o,
  output half_t half_c_o,
  output half_t half_fb_o
);
  half_t fb_base;

  always_comb begin
    unique case (sel_i.fb)
      2'b00:   fb_base = half_t'(4);
      2'b01:   fb_base = half_t'(8);
      2'b10:   fb_base = half_t'(6);
      default: fb_base = half_t'(12);
    endcase
    half_a_o  = scale_half(sel_i.a ? half_t'(4) : half_t'(2), sel_i.vco);
    half_b_o  = scale_half(sel_i.b ? half_t'(4) : half_t'(2), sel_i.vco);
    half_c_o  = scale_half(sel_i.c ? half_t'(6) : half_t'(4), sel_i.vco);
    half_fb_o = scale_half(fb_base, sel_i.vco);
  end
endmodule

// File: rtl/clkdiv_even_div.sv
`timescale 1ns/1ps
module clkdiv_even_div #(
  parameter int CNT_W = 6,
  parameter bit GATED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic             run_req_i,
  output logic             ph_o,
  output logic             out_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, last_c;
  logic             ph_q, ph_nx;

  assign last_c = (half_i << 1) - {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    ph_nx  = (cnt_q < half_i);
    cnt_nx = (cnt_q == last_c) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      ph_q  <= ph_nx;
    end
  end

  assign ph_o = ph_q;

  if (GATED) begin : g_gate
    logic run_q, run_nx, out_q;
    // stop request only sampled while the phase is low
    assign run_nx = ph_q ? run_q : run_req_i;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        run_q <= 1'b0;
        out_q <= 1'b0;
      end else begin
        run_q <= run_nx;
        out_q <= ph_nx & run_nx;
      end
    end
    assign out_o = out_q;
  end else begin : g_free
    logic unused_run;
    assign unused_run = run_req_i;
    assign out_o      = ph_q;
  end
endmodule

// File: rtl/clkdiv_bank_top.sv
`timescale 1ns/1ps
module clkdiv_bank_top
  import clkdiv_pkg::*;
#(
  parameter int NUM_A = 5,
  parameter int NUM_B = 5,
  parameter int NUM_C = 4
) (
  input  logic             osc_clk_i,
  input  logic             ref0_clk_i,
  input  logic             ref1_clk_i,
  input  logic             ref_sel_i,
  input  logic             pll_en_i,
  input  logic             vco_sel_i,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  input  logic             sel_c_i,
  input  logic [1:0]       fb_sel_i,
  input  logic             clk_stop_n_i,
  input  logic             mr_oe_n_i,
  output logic [NUM_A-1:0] bank_a_o,
  output logic [NUM_B-1:0] bank_b_o,
  output logic [NUM_C-1:0] bank_c_o,
  output logic             fb_o
);
  localparam int NBANK = 3;

  logic             src_clk;
  logic             rst;
  sel_t             sel_q;
  half_t            half_bank [NBANK];
  half_t            half_fb;
  logic [NBANK-1:0] ph_bank, out_bank;
  logic             fb_ph, fb_out;

  assign rst = ~mr_oe_n_i;

  clkdiv_src_mux u_mux (
    .osc_clk_i (osc_clk_i),
    .ref0_clk_i(ref0_clk_i),
    .ref1_clk_i(ref1_clk_i),
    .ref_sel_i (ref_sel_i),
    .pll_en_i  (pll_en_i),
    .src_clk_o (src_clk)
  );

  // selects follow the pins only while held in reset
  always_ff @(posedge src_clk) begin
    if (rst) begin
      sel_q <= '{vco: vco_sel_i, a: sel_a_i, b: sel_b_i, c: sel_c_i, fb: fb_sel_i};
    end
  end

  clkdiv_ratio_dec u_dec (
    .sel_i    (sel_q),
    .half_a_o (half_bank[0]),
    .half_b_o (half_bank[1]),
    .half_c_o (half_bank[2]),
    .half_fb_o(half_fb)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    clkdiv_even_div #(.CNT_W(CNT_W), .GATED(1'b1)) u_div (
      .clk_i    (src_clk),
      .rst_i    (rst),
      .half_i   (half_bank[g]),
      .run_req_i(clk_stop_n_i),
      .ph_o     (ph_bank[g]),
      .out_o    (out_bank[g])
    );
  end

  clkdiv_even_div #(.CNT_W(CNT_W), .GATED(1'b0)) u_fb_div (
    .clk_i    (src_clk),
    .rst_i    (rst),
    .half_i   (half_fb),
    .run_req_i(1'b1),
    .ph_o     (fb_ph),
    .out_o    (fb_out)
  );

  assign bank_a_o = mr_oe_n_i ? {NUM_A{out_bank[0]}} : {NUM_A{1'bz}};
  assign bank_b_o = mr_oe_n_i ? {NUM_B{out_bank[1]}} : {NUM_B{1'bz}};
  assign bank_c_o = mr_oe_n_i ? {NUM_C{out_bank[2]}} : {NUM_C{1'bz}};
  assign fb_o     = mr_oe_n_i ? fb_out : 1'bz;
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk #(
  parameter int NBANK = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [NBANK-1:0] ph_i,
  input logic [NBANK-1:0] out_i,
  input logic             fb_i,
  input clkdiv_pkg::sel_t sel_i
);
  for (genvar g = 0; g < NBANK; g++) begin : g_chk
    // R9
    rise_at_phase_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(out_i[g]) |-> $rose(ph_i[g]));
    // R9
    fall_with_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(out_i[g]) |-> $fell(ph_i[g]));
    // R8
    out_within_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      out_i[g] |-> ph_i[g]);
  end

  // R10
  cleared_by_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (ph_i == '0 && !fb_i));

  // R7
  first_edge_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(rst_i, 2) && !$past(rst_i)) |-> (ph_i == '1 && fb_i));

  // R11
  sel_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> $stable(sel_i));
endmodule

bind clkdiv_bank_top clkdiv_bank_chk #(.NBANK(3)) u_chk (
  .clk_i(src_clk),
  .rst_i(rst),
  .ph_i (ph_bank),
  .out_i(out_bank),
  .fb_i (fb_ph),
  .sel_i(sel_q)
);

// File: tb/clkdiv_bank_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_bank_top_tb_top;
  localparam int NA = 5;
  localparam int NB = 5;
  localparam int NC = 4;

  typedef struct packed {
    logic       v, a, b, c;
    logic [1:0] fb;
    logic [5:0] na, nb, nc, nf;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd4,  6'd4,  6'd8,  6'd8},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 6'd8,  6'd8,  6'd12, 6'd16},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 6'd4,  6'd8,  6'd8,  6'd12},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd8,  6'd4,  6'd12, 6'd24},
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 6'd8,  6'd8,  6'd16, 6'd16},
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 6'd16, 6'd16, 6'd24, 6'd32},
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 6'd8,  6'd16, 6'd24, 6'd24},
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 6'd16, 6'd8,  6'd16, 6'd48}
  };

  logic osc_clk = 1'b0, ref0 = 1'b0, ref1 = 1'b0, ref0_run = 1'b1;
  logic ref_sel = 1'b0, pll_en = 1'b1, vco_sel = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
  logic [1:0] fb_sel = 2'b00;
  logic clk_stop_n = 1'b1, mr_oe_n = 1'b0;
  logic [NA-1:0] bank_a;
  logic [NB-1:0] bank_b;
  logic [NC-1:0] bank_c;
  logic fb;
  int checks = 0, errors = 0;

  always #10 osc_clk = ~osc_clk;
  always #35 if (ref0_run) ref0 = ~ref0;
  always #55 ref1 = ~ref1;

  clkdiv_bank_top #(.NUM_A(NA), .NUM_B(NB), .NUM_C(NC)) dut_i (
    .osc_clk_i(osc_clk), .ref0_clk_i(ref0), .ref1_clk_i(ref1),
    .ref_sel_i(ref_sel), .pll_en_i(pll_en), .vco_sel_i(vco_sel),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c), .fb_sel_i(fb_sel),
    .clk_stop_n_i(clk_stop_n), .mr_oe_n_i(mr_oe_n),
    .bank_a_o(bank_a), .bank_b_o(bank_b), .bank_c_o(bank_c), .fb_o(fb)
  );

  function automatic logic wave(int k, int n);
    return ((k - 1) % n) < (n / 2);
  endfunction

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // R10: hold reset with the given selects and confirm no output drives high
  task automatic apply_reset(vec_t v);
    @(negedge osc_clk);
    mr_oe_n = 1'b0;
    {vco_sel, sel_a, sel_b, sel_c, fb_sel} = {v.v, v.a, v.b, v.c, v.fb};
    repeat (20) @(negedge osc_clk);
    chk(((bank_a === '0) || (bank_a === {NA{1'bz}})) &&
        ((bank_b === '0) || (bank_b === {NB{1'bz}})) &&
        ((bank_c === '0) || (bank_c === {NC{1'bz}})) &&
        ((fb === 1'b0) || (fb === 1'bz)),
        "R10 outputs undriven in reset", longint'({bank_a, bank_b, bank_c, fb}), 0);
  endtask

  task automatic meas_period(output longint p);
    longint t1;
    @(posedge bank_a[0]);
    t1 = $time;
    @(posedge bank_a[0]);
    p = $time - t1;
  endtask

  initial begin
    repeat (150000) @(posedge osc_clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad_a, bad_b, bad_c, bad_f;
    longint per;
    logic [NA+NB+NC:0] snap;

    // vector table: ratios, uniform banks, duty, frozen selects
    for (int i = 0; i < 8; i++) begin
      apply_reset(VEC[i]);
      mr_oe_n = 1'b1;
      // R11: scramble selects right after release
      {vco_sel, sel_a, sel_b, sel_c, fb_sel} = ~{VEC[i].v, VEC[i].a, VEC[i].b, VEC[i].c, VEC[i].fb};
      bad_a = 0; bad_b = 0; bad_c = 0; bad_f = 0;
      for (int k = 1; k <= 96; k++) begin
        @(negedge osc_clk);
        if (bank_a !== {NA{wave(k, int'(VEC[i].na))}}) bad_a++;
        if (bank_b !== {NB{wave(k, int'(VEC[i].nb))}}) bad_b++;
        if (bank_c !== {NC{wave(k, int'(VEC[i].nc))}}) bad_c++;
        if (fb !== wave(k, int'(VEC[i].nf))) bad_f++;
      end
      chk(bad_a == 0, $sformatf("R3 R6 R7 R11 bank A vector %0d mismatching samples", i), bad_a, 0);
      chk(bad_b == 0, $sformatf("R3 R6 R7 R11 bank B vector %0d mismatching samples", i), bad_b, 0);
      chk(bad_c == 0, $sformatf("R4 R6 R7 R11 bank C vector %0d mismatching samples", i), bad_c, 0);
      chk(bad_f == 0, $sformatf("R5 R7 R11 feedback vector %0d mismatching samples", i), bad_f, 0);
    end

    // clock-stop: parking, feedback unaffected, whole pulses, restart phase
    begin
      int stop_bad, fb_bad, run_a, run_c, runs_bad, phase_bad;
      stop_bad = 0; fb_bad = 0; run_a = 0; run_c = 0; runs_bad = 0; phase_bad = 0;
      apply_reset(VEC[0]);
      mr_oe_n = 1'b1;
      for (int k = 1; k <= 140; k++) begin
        @(negedge osc_clk);
        if (fb !== wave(k, 8)) fb_bad++;
        if (k >= 30 && k <= 70 && {bank_a, bank_b, bank_c} !== '0) stop_bad++;
        if (k >= 100 && (bank_c !== {NC{wave(k, 8)}} || bank_a !== {NA{wave(k, 4)}})) phase_bad++;
        if (bank_c[0] === 1'b1) run_c++;
        else begin
          if (run_c != 0 && run_c != 4) runs_bad++;
          run_c = 0;
        end
        if (bank_a[0] === 1'b1) run_a++;
        else begin
          if (run_a != 0 && run_a != 2) runs_bad++;
          run_a = 0;
        end
        if (k == 10) clk_stop_n = 1'b0;
        if (k == 70) clk_stop_n = 1'b1;
      end
      chk(stop_bad == 0, "R8 bank outputs parked low while stopped", stop_bad, 0);
      chk(fb_bad == 0, "R8 feedback keeps running during stop", fb_bad, 0);
      chk(runs_bad == 0, "R9 high pulses of full length across stop and restart", runs_bad, 0);
      chk(phase_bad == 0, "R9 restarted outputs back in phase", phase_bad, 0);
    end

    // bypass from reference 0
    pll_en = 1'b0;
    ref_sel = 1'b0;
    apply_reset(VEC[0]);
    mr_oe_n = 1'b1;
    repeat (2) @(posedge bank_a[0]);
    meas_period(per);
    chk(per == 4 * 70, "R1 R2 bypass period from reference 0", per, 4 * 70);

    // bypass from reference 1
    ref_sel = 1'b1;
    repeat (3) @(posedge bank_a[0]);
    meas_period(per);
    chk(per == 4 * 110, "R1 bypass period from reference 1", per, 4 * 110);

    // static reference holds outputs
    ref_sel = 1'b0;
    ref0_run = 1'b0;
    #1000;
    snap = {bank_a, bank_b, bank_c, fb};
    #1000;
    chk({bank_a, bank_b, bank_c, fb} === snap, "R2 static reference freezes outputs",
        longint'({bank_a, bank_b, bank_c, fb}), longint'(snap));
    ref0_run = 1'b1;

    // back to oscillator
    pll_en = 1'b1;
    repeat (3) @(posedge bank_a[0]);
    meas_period(per);
    chk(per == 4 * 20, "R2 oscillator period with divider enabled", per, 4 * 20);

    // R10: reset again and confirm clean restart on the oscillator
    apply_reset(VEC[2]);
    mr_oe_n = 1'b1;
    @(negedge osc_clk);
    chk({bank_a[0], bank_b[0], bank_c[0], fb} === 4'b1111,
        "R10 R7 all outputs high on first edge after release",
        longint'({bank_a[0], bank_b[0], bank_c[0], fb}), 15);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule